// File: doc/BRIEF.md
# Page-Buffered Flash Write Engine

This block is the write path of a byte-wide, page-programmed nonvolatile memory, modelled with clock-cycle timing. It watches the active-low chip-select, write-strobe and output-enable pins. It collects byte writes into a page-sized staging buffer. When no further write arrives within a load window, it commits the page. The commit first erases every byte of the selected page to all ones. It then writes each staged byte, and every byte that was not staged stays all ones.

Reads behave like an asynchronous static RAM and return array contents in the same cycle. While a commit is running, every read returns a status word instead of array data. The top bit of that word is the inverse of the top bit of the most recently accepted byte, which lets software poll for the end of the commit. The array is a plain register file. The address width and all timing windows are parameters counted in clock cycles, and a busy output shows when a commit is in progress.

Top module: `flash_page_writer`

## Requirements
- R1: `dout_oe` is 1 exactly when `ce_n`=0, `oe_n`=0 and `we_n`=1. Read data appears on `dout` in the same cycle. `dout` is all zeros whenever `dout_oe` is 0.
- R2: A write strobe is active while `ce_n`=0, `we_n`=0 and `oe_n`=1. The byte address is sampled in the first cycle the strobe is active, which is when the later of `ce_n` and `we_n` falls.
- R3: The stored byte is the `din` value sampled in the last active cycle of the strobe, that is, when the first of `ce_n` and `we_n` rises. `din` after that is ignored.
- R4: A strobe that is active for fewer than MIN_PULSE_CYC sampled cycles stages nothing and does not start a commit.
- R5: Holding `oe_n` low prevents any write. A strobe that ends because `oe_n` falls is discarded.
- R6: Address bits [PAGE_BITS-1:0] select the byte within the page, and bytes may be staged in any order. The page committed is the one given by bits [ADDR_W-1:PAGE_BITS] of the first staged byte.
- R7: `program_busy` rises LOAD_WIN_CYC cycles after the clock edge that samples the end of the last staged byte. Any strobe within that window restarts the window.
- R8: `program_busy` stays high for exactly PROG_CYC cycles (PROG_CYC must be at least 2^(PAGE_BITS+1)+1).
- R9: After a commit, staged bytes hold their data and unstaged bytes of the page read 8'hFF. Other pages are unchanged.
- R10: While `program_busy` is high, a read at any address returns bit 7 equal to the inverse of bit 7 of the last staged byte, with bits 6..0 zero.
- R11: Byte writes during `program_busy` are ignored. They neither change the array nor start another commit.
- R12: After reset, `program_busy` is 0 and every array byte reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data or polling status |
| dout_oe | output | 1 | High when `dout` should drive the bus |
| program_busy | output | 1 | Page commit in progress |

## Verification
Reads are combinational, so the bench samples `dout` one nanosecond after it sets up a read and before the next clock edge. A write's end is sampled at the first rising edge after the bench releases the strobe. `program_busy` must still be low at the negedge LOAD_WIN_CYC cycles later and high at the following one. It must still be high PROG_CYC-1 negedges after that and low one negedge later. The bench drives all pins on negedges and checks them only at negedges or shortly after. This keeps every expected edge exactly one register away from its stimulus.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LOAD,
        PH_ERASE,
        PH_PROG,
        PH_SETTLE
    } pgw_phase_e;

endpackage

// File: rtl/pgw_strobe_decode.sv
module pgw_strobe_decode #(
    parameter int ADDR_W        = 11,
    parameter int DATA_W        = 8,
    parameter int MIN_PULSE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              strobe_on,
    output logic              ld_fire,
    output logic [ADDR_W-1:0] ld_addr,
    output logic [DATA_W-1:0] ld_data
);

    localparam int WID_W = $clog2(MIN_PULSE_CYC + 1);

    typedef struct packed {
        logic              act;
        logic [WID_W-1:0]  wid;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } strobe_t;

    strobe_t s_d, s_q;

    // combined strobe: both selects low with output enable high
    assign strobe_on = ~ce_n & ~we_n & oe_n;

    always_comb begin
        s_d     = s_q;
        s_d.act = strobe_on;
        if (strobe_on && !s_q.act) begin
            // later falling select opens the strobe: take the address now
            s_d.addr = addr;
            s_d.data = din;
            s_d.wid  = WID_W'(1);
        end else if (strobe_on) begin
            // keep tracking data until the first select rises
            s_d.data = din;
            if (s_q.wid < WID_W'(MIN_PULSE_CYC))
                s_d.wid = s_q.wid + WID_W'(1);
        end
    end

    // a load counts only if released by a select (not by oe) and wide enough
    assign ld_fire = s_q.act & ~strobe_on & oe_n & (s_q.wid >= WID_W'(MIN_PULSE_CYC));
    assign ld_addr = s_q.addr;
    assign ld_data = s_q.data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/pgw_page_buffer.sv
module pgw_page_buffer #(
    parameter int DATA_W    = 8,
    parameter int PAGE_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [PAGE_BITS-1:0] wr_idx,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 clr,
    input  logic [PAGE_BITS-1:0] rd_idx,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_valid
);

    localparam int PAGE_BYTES = 1 << PAGE_BITS;

    typedef struct packed {
        logic [PAGE_BYTES-1:0][DATA_W-1:0] data;
        logic [PAGE_BYTES-1:0]             vld;
    } pbuf_t;

    pbuf_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (clr)
            b_d.vld = '0;
        if (wr_en) begin
            b_d.data[wr_idx] = wr_data;
            b_d.vld[wr_idx]  = 1'b1;
        end
    end

    assign rd_data  = b_q.data[rd_idx];
    assign rd_valid = b_q.vld[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

endmodule

// File: rtl/pgw_sequencer.sv
module pgw_sequencer
    import pgw_pkg::*;
#(
    parameter int ADDR_W       = 11,
    parameter int DATA_W       = 8,
    parameter int PAGE_BITS    = 6,
    parameter int LOAD_WIN_CYC = 40,
    parameter int PROG_CYC     = 200
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        strobe_on,
    input  logic                        ld_fire,
    input  logic [ADDR_W-PAGE_BITS-1:0] ld_page,
    input  logic                        ld_msb,
    input  logic [DATA_W-1:0]           buf_rd_data,
    input  logic                        buf_rd_valid,
    output logic                        buf_we,
    output logic                        buf_clr,
    output logic [PAGE_BITS-1:0]        buf_rd_idx,
    output logic                        arr_we,
    output logic [ADDR_W-1:0]           arr_waddr,
    output logic [DATA_W-1:0]           arr_wdata,
    output logic                        busy,
    output logic [DATA_W-1:0]           poll_word
);

    localparam int PG_W  = ADDR_W - PAGE_BITS;
    localparam int WIN_W = $clog2(LOAD_WIN_CYC + 1);
    localparam int CYC_W = $clog2(PROG_CYC + 1);
    localparam logic [PAGE_BITS-1:0] IDX_LAST = {PAGE_BITS{1'b1}};

    typedef struct packed {
        pgw_phase_e           phase;
        logic [PG_W-1:0]      page;
        logic [WIN_W-1:0]     win;
        logic [CYC_W-1:0]     cyc;
        logic [PAGE_BITS-1:0] idx;
        logic                 last_msb;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        arr_we    = 1'b0;
        arr_waddr = {s_q.page, s_q.idx};
        arr_wdata = '1;
        buf_clr   = 1'b0;
        case (s_q.phase)
            PH_IDLE: begin
                if (ld_fire) begin
                    s_d.phase    = PH_LOAD;
                    s_d.page     = ld_page;
                    s_d.win      = '0;
                    s_d.last_msb = ld_msb;
                end
            end
            PH_LOAD: begin
                if (ld_fire) begin
                    s_d.last_msb = ld_msb;
                    s_d.win      = '0;
                end else if (strobe_on) begin
                    s_d.win = '0;
                end else if (s_q.win == WIN_W'(LOAD_WIN_CYC - 1)) begin
                    s_d.phase = PH_ERASE;
                    s_d.cyc   = '0;
                    s_d.idx   = '0;
                end else begin
                    s_d.win = s_q.win + WIN_W'(1);
                end
            end
            PH_ERASE: begin
                arr_we    = 1'b1;
                arr_wdata = '1;
                s_d.cyc   = s_q.cyc + CYC_W'(1);
                if (s_q.idx == IDX_LAST) begin
                    s_d.phase = PH_PROG;
                    s_d.idx   = '0;
                end else begin
                    s_d.idx = s_q.idx + PAGE_BITS'(1);
                end
            end
            PH_PROG: begin
                arr_we    = 1'b1;
                arr_wdata = buf_rd_valid ? buf_rd_data : '1;
                s_d.cyc   = s_q.cyc + CYC_W'(1);
                if (s_q.idx == IDX_LAST) begin
                    s_d.phase = PH_SETTLE;
                    s_d.idx   = '0;
                end else begin
                    s_d.idx = s_q.idx + PAGE_BITS'(1);
                end
            end
            PH_SETTLE: begin
                s_d.cyc = s_q.cyc + CYC_W'(1);
                if (s_q.cyc == CYC_W'(PROG_CYC - 1)) begin
                    s_d.phase = PH_IDLE;
                    buf_clr   = 1'b1;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    assign busy       = (s_q.phase == PH_ERASE) || (s_q.phase == PH_PROG) ||
                        (s_q.phase == PH_SETTLE);
    assign buf_we     = ld_fire & ~busy;
    assign buf_rd_idx = s_q.idx;
    assign poll_word  = {~s_q.last_msb, {(DATA_W-1){1'b0}}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{phase: PH_IDLE, default: '0};
        else        s_q <= s_d;
    end

endmodule

// File: rtl/pgw_array.sv
module pgw_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0][DATA_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we)
            mem_d[waddr] = wdata;
    end

    assign rdata = mem_q[raddr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '1;
        else        mem_q <= mem_d;
    end

endmodule

// File: rtl/flash_page_writer.sv
module flash_page_writer #(
    parameter int ADDR_W        = 11,
    parameter int DATA_W        = 8,
    parameter int PAGE_BITS     = 6,
    parameter int LOAD_WIN_CYC  = 40,
    parameter int PROG_CYC      = 200,
    parameter int MIN_PULSE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    output logic              program_busy
);

    logic                 strobe_on;
    logic                 ld_fire;
    logic [ADDR_W-1:0]    ld_addr;
    logic [DATA_W-1:0]    ld_data;
    logic                 buf_we;
    logic                 buf_clr;
    logic [PAGE_BITS-1:0] buf_rd_idx;
    logic [DATA_W-1:0]    buf_rd_data;
    logic                 buf_rd_valid;
    logic                 arr_we;
    logic [ADDR_W-1:0]    arr_waddr;
    logic [DATA_W-1:0]    arr_wdata;
    logic [DATA_W-1:0]    arr_rdata;
    logic [DATA_W-1:0]    poll_word;

    pgw_strobe_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_PULSE_CYC(MIN_PULSE_CYC)
    ) u_strobe (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .strobe_on(strobe_on), .ld_fire(ld_fire),
        .ld_addr(ld_addr), .ld_data(ld_data)
    );

    pgw_page_buffer #(
        .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS)
    ) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_en(buf_we),
        .wr_idx(ld_addr[PAGE_BITS-1:0]), .wr_data(ld_data), .clr(buf_clr),
        .rd_idx(buf_rd_idx), .rd_data(buf_rd_data), .rd_valid(buf_rd_valid)
    );

    pgw_sequencer #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS),
        .LOAD_WIN_CYC(LOAD_WIN_CYC), .PROG_CYC(PROG_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .strobe_on(strobe_on), .ld_fire(ld_fire),
        .ld_page(ld_addr[ADDR_W-1:PAGE_BITS]), .ld_msb(ld_data[DATA_W-1]),
        .buf_rd_data(buf_rd_data), .buf_rd_valid(buf_rd_valid),
        .buf_we(buf_we), .buf_clr(buf_clr), .buf_rd_idx(buf_rd_idx),
        .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata),
        .busy(program_busy), .poll_word(poll_word)
    );

    pgw_array #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_array (
        .clk(clk), .rst_n(rst_n), .we(arr_we), .waddr(arr_waddr),
        .wdata(arr_wdata), .raddr(addr), .rdata(arr_rdata)
    );

    assign dout_oe = ~ce_n & ~oe_n & we_n;
    assign dout    = !dout_oe     ? '0 :
                     program_busy ? poll_word : arr_rdata;

endmodule

// File: rtl/pgw_checker.sv
module pgw_checker #(
    parameter int DATA_W   = 8,
    parameter int PROG_CYC = 200
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              we_n,
    input logic              oe_n,
    input logic [DATA_W-1:0] dout,
    input logic              dout_oe,
    input logic              program_busy,
    input logic              ld_fire,
    input logic              buf_we
);

    int busy_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            busy_len_q <= 0;
        else if (program_busy) busy_len_q <= busy_len_q + 1;
        else                   busy_len_q <= 0;
    end

    p_read_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n || !we_n) |-> (!dout_oe && dout == '0));

    p_oe_inhibit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_fire |-> oe_n);

    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(program_busy) |=> program_busy);

    p_busy_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(program_busy) |-> (busy_len_q == PROG_CYC));

    p_poll_low_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (program_busy && dout_oe) |-> (dout[DATA_W-2:0] == '0));

    p_busy_ignores_r11: assert property (@(posedge clk) disable iff (!rst_n)
        program_busy |-> !buf_we);

endmodule

bind flash_page_writer pgw_checker #(
    .DATA_W(DATA_W), .PROG_CYC(PROG_CYC)
) u_pgw_checker (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .dout(dout), .dout_oe(dout_oe), .program_busy(program_busy),
    .ld_fire(ld_fire), .buf_we(buf_we)
);

// File: tb/flash_page_writer_bench.sv
module flash_page_writer_bench;

    localparam int AW   = 9;
    localparam int DW   = 8;
    localparam int PB   = 6;
    localparam int WIN  = 12;
    localparam int PROG = 140;
    localparam int MINP = 2;
    localparam int NPG  = 1 << PB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_oe;
    logic          program_busy;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [DW-1:0] model [1<<AW];
    logic [DW-1:0] pend_d [NPG];
    bit            pend_v [NPG];
    logic [AW-PB-1:0] pend_pg;
    bit            pend_any;
    logic [DW-1:0] last_d;

    always #2 clk = ~clk;

    flash_page_writer #(
        .ADDR_W(AW), .DATA_W(DW), .PAGE_BITS(PB), .LOAD_WIN_CYC(WIN),
        .PROG_CYC(PROG), .MIN_PULSE_CYC(MINP)
    ) u_flash_page_writer (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
        .program_busy(program_busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // read at the current negedge; settles and samples before the next edge
    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v, output logic oe);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        #1;
        v = dout; oe = dout_oe;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    // raw strobe, held for MINP sampled edges; returns at the release negedge
    task automatic strobe(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        addr = a; din = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        repeat (MINP) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic stage(input logic [AW-1:0] a, input logic [DW-1:0] d);
        if (!pend_any) begin pend_pg = a[AW-1:PB]; pend_any = 1'b1; end
        pend_d[a[PB-1:0]] = d; pend_v[a[PB-1:0]] = 1'b1; last_d = d;
        strobe(a, d);
    endtask

    // called at the release negedge of the last staged byte
    task automatic commit(input string tag);
        logic [DW-1:0] v; logic oe;
        repeat (WIN) @(negedge clk);
        chk({tag, " R7 busy still low at window end"}, program_busy, 0);
        @(negedge clk);
        chk({tag, " R7 busy rises after window"}, program_busy, 1);
        rd(9'h1A5, v, oe);
        chk({tag, " R10 poll word"}, v, {~last_d[7], 7'b0});
        repeat (PROG - 1) @(negedge clk);
        chk({tag, " R8 busy held"}, program_busy, 1);
        @(negedge clk);
        chk({tag, " R8 busy drops"}, program_busy, 0);
        for (int i = 0; i < NPG; i++) begin
            model[{pend_pg, i[PB-1:0]}] = pend_v[i] ? pend_d[i] : 8'hFF;
            pend_v[i] = 1'b0;
        end
        pend_any = 1'b0;
    endtask

    task automatic verify_page(input logic [AW-PB-1:0] pg, input string tag);
        logic [DW-1:0] v; logic oe;
        int bad = 0;
        for (int i = 0; i < NPG; i++) begin
            @(negedge clk);
            rd({pg, i[PB-1:0]}, v, oe);
            if (v !== model[{pg, i[PB-1:0]}]) begin
                bad++;
                $display("FAIL %s page %0d byte %0d actual=%0h expected=%0h",
                         tag, pg, i, v, model[{pg, i[PB-1:0]}]);
            end
        end
        n_checks++;
        if (bad != 0) n_fail++;
    endtask

    task automatic t_reset;
        logic [DW-1:0] v; logic oe;
        @(negedge clk);
        chk("R12 busy after reset", program_busy, 0);
        chk("R1 no drive when idle", dout_oe, 0);
        verify_page(0, "R12 erased array");
        @(negedge clk);
        rd(9'h1FF, v, oe);
        chk("R12 top byte erased", v, 8'hFF);
        chk("R1 drive on read", oe, 1);
    endtask

    task automatic t_read_gate;
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; #1;
        chk("R1 oe high blocks drive", {dout_oe, dout}, 0);
        ce_n = 1'b1; oe_n = 1'b0; #1;
        chk("R1 ce high blocks drive", {dout_oe, dout}, 0);
        oe_n = 1'b1;
    endtask

    task automatic t_page_any_order;
        stage(9'h085, 8'h5A);   // page 2, byte 5
        stage(9'h080, 8'h01);
        // idle WIN-3 cycles, then another strobe restarts the window
        repeat (WIN - 3) @(negedge clk);
        chk("R7 no commit while window open", program_busy, 0);
        stage(9'h0BF, 8'hC3);
        stage(9'h091, 8'h77);
        commit("page2");
        verify_page(2, "R9 R6 page2 contents");
        verify_page(3, "R9 neighbour page untouched");
    endtask

    task automatic t_glitch;
        logic [DW-1:0] v; logic oe;
        @(negedge clk);
        addr = 9'h0C4; din = 8'h12; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        repeat (WIN + 5) @(negedge clk);
        chk("R4 short pulse no commit", program_busy, 0);
        rd(9'h0C4, v, oe);
        chk("R4 short pulse no data", v, 8'hFF);
    endtask

    task automatic t_oe_inhibit;
        logic [DW-1:0] v; logic oe;
        @(negedge clk);
        addr = 9'h0D0; din = 8'h34; oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0;
        repeat (3) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        // strobe ended by oe falling
        @(negedge clk);
        addr = 9'h0D1; din = 8'h56; ce_n = 1'b0; we_n = 1'b0;
        repeat (3) @(negedge clk);
        oe_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        repeat (WIN + 5) @(negedge clk);
        chk("R5 oe low no commit", program_busy, 0);
        rd(9'h0D0, v, oe);
        chk("R5 oe low held", v, 8'hFF);
        @(negedge clk);
        rd(9'h0D1, v, oe);
        chk("R5 oe fall release", v, 8'hFF);
    endtask

    task automatic t_strobe_edges;
        // ce falls first at A, we falls later at B; data changes until release
        @(negedge clk);
        addr = 9'h0E0; din = 8'h11; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        addr = 9'h0F3; din = 8'h22; we_n = 1'b0;
        @(negedge clk);
        addr = 9'h0E0; din = 8'h33;
        @(negedge clk);
        we_n = 1'b1; din = 8'h44;
        pend_pg = 3'd3; pend_any = 1'b1;
        pend_d[6'h33] = 8'h33; pend_v[6'h33] = 1'b1; last_d = 8'h33;
        @(negedge clk);
        ce_n = 1'b1;
        // release was sampled one negedge earlier; commit counts from there
        repeat (WIN - 1) @(negedge clk);
        chk("R7 busy still low at window end", program_busy, 0);
        @(negedge clk);
        chk("R2 R3 commit starts", program_busy, 1);
        repeat (PROG) @(negedge clk);
        chk("R8 busy drops", program_busy, 0);
        for (int i = 0; i < NPG; i++) begin
            model[{pend_pg, i[PB-1:0]}] = pend_v[i] ? pend_d[i] : 8'hFF;
            pend_v[i] = 1'b0;
        end
        pend_any = 1'b0;
        verify_page(3, "R2 R3 address from last fall, data from first rise");
    endtask

    task automatic t_busy_ignore;
        stage(9'h100, 8'h9E);   // page 4
        commit_with_intrusion();
        verify_page(4, "R9 page4 contents");
        verify_page(5, "R11 page5 untouched");
    endtask

    task automatic commit_with_intrusion;
        repeat (WIN + 3) @(negedge clk);
        chk("R7 busy for page4", program_busy, 1);
        strobe(9'h145, 8'h00);  // page 5, during busy
        repeat (PROG + 10) @(negedge clk);
        chk("R11 busy not restarted", program_busy, 0);
        repeat (WIN + 5) @(negedge clk);
        chk("R11 no second commit", program_busy, 0);
        model[9'h100] = 8'h9E;
        for (int i = 1; i < NPG; i++) model[{3'd4, i[PB-1:0]}] = 8'hFF;
        for (int i = 0; i < NPG; i++) pend_v[i] = 1'b0;
        pend_any = 1'b0;
    endtask

    task automatic t_first_page_wins;
        stage(9'h181, 8'hA1);   // page 6, byte 1
        stage(9'h1C2, 8'hB2);   // page 7 address, byte 2 -> lands in page 6
        commit("R6 first page");
        verify_page(6, "R6 page6 holds both bytes");
        verify_page(7, "R6 page7 untouched");
    endtask

    task automatic t_reprogram;
        stage(9'h0A0, 8'h3C);   // page 2 again, one byte
        commit("R9 reprogram");
        verify_page(2, "R9 erase before write");
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) model[i] = 8'hFF;
        for (int i = 0; i < NPG; i++) begin pend_v[i] = 1'b0; pend_d[i] = '0; end
        pend_any = 1'b0; pend_pg = '0; last_d = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read_gate();
        t_page_any_order();
        t_glitch();
        t_oe_inhibit();
        t_strobe_edges();
        t_busy_ignore();
        t_first_page_wins();
        t_reprogram();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule